// File: doc/BRIEF.md
# ROM Patch Address Redirect Unit

This peripheral lets software repair a few instructions of a program held in read-only memory. It sits beside an 8-bit processor whose address bus is 16 bits wide and holds two patch slots. Each slot has a 16-bit target address and an enable bit. All of these are reached through a byte-wide register bus with a combinational read path and a write that is captured on the clock edge.

The block watches every instruction fetch. When the processor flags a cycle as an opcode fetch and the fetch address equals the address of an enabled slot, the unit raises a redirect request in that same cycle. It also drives a fixed RAM vector address: 0x0300 for the first slot and 0x0320 for the second. The processor then runs the patch routine found at that vector. Returning to the main program is done by a jump at the end of the routine, which is not this block's concern. Software is expected to program different addresses into the two slots. If it does not, the first slot wins so that the output stays defined.

Top module: `rom_patch_redirect`

## Requirements
- R1: After a synchronous active-low reset, both slot addresses read back as 0x0000 and the enable register reads 0x00, so no fetch is redirected.
- R2: Slot 1's address is written and read at register 0x020A (bits 15:8) and register 0x020B (bits 7:0), and it reads back exactly what was written.
- R3: Slot 2's address is written and read at register 0x020C (bits 15:8) and register 0x020D (bits 7:0), and it reads back exactly what was written.
- R4: The enable register is at 0x020E. Bit 0 enables slot 1 and bit 1 enables slot 2, with 1 meaning enabled. Bits 7:2 ignore writes and always read 0.
- R5: In a cycle with the opcode-fetch strobe high and the fetch address equal to an enabled slot's address, redirect is 1 in that same cycle. The redirect address is 0x0300 for slot 1 and 0x0320 for slot 2.
- R6: A slot whose enable bit is 0 never causes a redirect, whatever its address holds.
- R7: When the opcode-fetch strobe is 0 (an operand or data fetch), redirect is 0 for any fetch address.
- R8: When both enabled slots match the same opcode fetch, the redirect address is 0x0300 (slot 1 wins).
- R9: Whenever redirect is 0, the redirect address output is 0x0000.
- R10: Reads of any register address other than 0x020A to 0x020E return 0x00, and writes to such addresses change no slot address or enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_addr | input | 16 | Register bus address |
| reg_wdata | input | 8 | Register bus write data |
| reg_we | input | 1 | Register write strobe, captured on the rising edge |
| reg_rdata | output | 8 | Register read data for reg_addr, combinational |
| fetch_addr | input | 16 | Address of the current processor fetch |
| fetch_opcode | input | 1 | High when the current fetch is an instruction's first byte |
| redirect | output | 1 | Redirect request for the current fetch |
| redirect_addr | output | 16 | RAM vector to continue at, 0x0000 when no redirect |

## Verification
The assertions assume that the register bus inputs and the fetch inputs hold known, settled values at every rising edge after reset. They also assume that a write strobe lasts exactly one cycle for each intended write. The bench meets this by driving every input to a defined value from time zero and changing inputs only on the falling edge. It pulses the write strobe for a single cycle per write. The random phase lets both slots collide on purpose, so the slot 1 priority path is exercised even though software is told to avoid that case.

// File: rtl/patch_pkg.sv
// Package: shared constants and helpers for the ROM patch redirect unit.
// Assumes an 8-bit data bus and a 16-bit address bus.
package patch_pkg;
    localparam int DATA_W      = 8;
    localparam int ADDR_W      = 2 * DATA_W;
    localparam int NUM_SLOTS   = 2;
    localparam int REG_BASE    = 'h020A;
    localparam int VEC_BASE    = 'h0300;
    localparam int VEC_STRIDE  = 'h0020;

    // Fixed RAM vector for a slot index.
    function automatic logic [ADDR_W-1:0] slot_vector(input int idx);
        return ADDR_W'(VEC_BASE + idx * VEC_STRIDE);
    endfunction
endpackage

// File: rtl/patch_regfile.sv
// Module: patch_regfile
// Holds the slot target addresses and the enable bits behind a byte-wide
// register bus. Slot i occupies BASE+2i (high byte) and BASE+2i+1 (low byte);
// the enable register follows directly after the last slot.
// Assumes reg_we is a single-cycle strobe per write; reads are combinational.
module patch_regfile
    import patch_pkg::*;
#(
    parameter int P_DATA_W = DATA_W,
    parameter int P_SLOTS  = NUM_SLOTS,
    parameter int P_BASE   = REG_BASE
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [2*P_DATA_W-1:0]                reg_addr,
    input  logic [P_DATA_W-1:0]                  reg_wdata,
    input  logic                                 reg_we,
    output logic [P_DATA_W-1:0]                  reg_rdata,
    output logic [P_SLOTS-1:0][2*P_DATA_W-1:0]   slot_addr,
    output logic [P_SLOTS-1:0]                   slot_en
);
    localparam int A_W = 2 * P_DATA_W;
    localparam logic [A_W-1:0] EN_ADDR = A_W'(P_BASE + 2 * P_SLOTS);

    genvar g;
    generate
        for (g = 0; g < P_SLOTS; g++) begin : g_slot
            localparam logic [A_W-1:0] HI_ADDR = A_W'(P_BASE + 2 * g);
            localparam logic [A_W-1:0] LO_ADDR = A_W'(P_BASE + 2 * g + 1);

            // Capture byte writes into this slot's target address.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    slot_addr[g] <= '0;
                end else if (reg_we) begin
                    if (reg_addr == HI_ADDR) slot_addr[g][P_DATA_W +: P_DATA_W] <= reg_wdata;
                    if (reg_addr == LO_ADDR) slot_addr[g][0 +: P_DATA_W]        <= reg_wdata;
                end
            end
        end
    endgenerate

    // Capture the enable bits; upper write data bits are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_en <= '0;
        end else if (reg_we && reg_addr == EN_ADDR) begin
            slot_en <= reg_wdata[P_SLOTS-1:0];
        end
    end

    // Combinational read mux; unmapped addresses return zero.
    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < P_SLOTS; i++) begin
            if (reg_addr == A_W'(P_BASE + 2 * i))     reg_rdata = slot_addr[i][P_DATA_W +: P_DATA_W];
            if (reg_addr == A_W'(P_BASE + 2 * i + 1)) reg_rdata = slot_addr[i][0 +: P_DATA_W];
        end
        if (reg_addr == EN_ADDR) reg_rdata = P_DATA_W'(slot_en);
    end

    // Reset leaves every slot disabled.
    assert_reset_disabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (slot_en == '0 && slot_addr == '0));

    // An enable write lands the low bits of the write data.
    assert_enable_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == EN_ADDR) |=> slot_en == $past(reg_wdata[P_SLOTS-1:0]));

    // Unused enable bits read back as zero.
    assert_enable_pad_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == EN_ADDR) |-> reg_rdata[P_DATA_W-1:P_SLOTS] == '0);

    // Without a write the stored slot addresses (R2, R3) do not move.
    assert_slot_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_we |=> ($stable(slot_addr) && $stable(slot_en)));
endmodule

// File: rtl/patch_match.sv
// Module: patch_match
// Compares an opcode fetch address against each enabled slot and picks the
// lowest-numbered hit. Purely combinational; assumes the fetch inputs are
// settled within the cycle.
module patch_match
    import patch_pkg::*;
#(
    parameter int P_ADDR_W = ADDR_W,
    parameter int P_SLOTS  = NUM_SLOTS
) (
    input  logic [P_ADDR_W-1:0]               fetch_addr,
    input  logic                              fetch_opcode,
    input  logic [P_SLOTS-1:0][P_ADDR_W-1:0]  slot_addr,
    input  logic [P_SLOTS-1:0]                slot_en,
    output logic                              redirect,
    output logic [P_ADDR_W-1:0]               redirect_addr
);
    logic [P_SLOTS-1:0] hit;

    genvar g;
    generate
        for (g = 0; g < P_SLOTS; g++) begin : g_cmp
            // One comparator per slot, qualified by enable and the opcode strobe.
            always_comb hit[g] = fetch_opcode && slot_en[g] && (fetch_addr == slot_addr[g]);
        end
    endgenerate

    // Priority select: scan from the top so the lowest index overwrites last.
    always_comb begin
        redirect      = |hit;
        redirect_addr = '0;
        for (int i = P_SLOTS - 1; i >= 0; i--) begin
            if (hit[i]) redirect_addr = P_ADDR_W'(slot_vector(i));
        end
    end
endmodule

// File: rtl/rom_patch_redirect.sv
// Module: rom_patch_redirect (top)
// Patch register file plus fetch comparator. Redirect and vector are produced
// in the same cycle as the opcode fetch. Assumes software keeps slot
// addresses distinct; if not, slot 1 wins.
module rom_patch_redirect
    import patch_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       reg_addr,
    input  logic [7:0]        reg_wdata,
    input  logic              reg_we,
    output logic [7:0]        reg_rdata,
    input  logic [15:0]       fetch_addr,
    input  logic              fetch_opcode,
    output logic              redirect,
    output logic [15:0]       redirect_addr
);
    logic [NUM_SLOTS-1:0][ADDR_W-1:0] slot_addr;
    logic [NUM_SLOTS-1:0]             slot_en;

    patch_regfile #(
        .P_DATA_W (DATA_W),
        .P_SLOTS  (NUM_SLOTS),
        .P_BASE   (REG_BASE)
    ) u_regfile (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_rdata (reg_rdata),
        .slot_addr (slot_addr),
        .slot_en   (slot_en)
    );

    patch_match #(
        .P_ADDR_W (ADDR_W),
        .P_SLOTS  (NUM_SLOTS)
    ) u_match (
        .fetch_addr    (fetch_addr),
        .fetch_opcode  (fetch_opcode),
        .slot_addr     (slot_addr),
        .slot_en       (slot_en),
        .redirect      (redirect),
        .redirect_addr (redirect_addr)
    );

    // Operand fetches never redirect.
    assert_operand_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_opcode |-> !redirect);

    // The vector output is zero when idle.
    assert_idle_vector_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !redirect |-> redirect_addr == '0);

    // Slot 1 wins whenever it matches.
    assert_slot1_priority_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_opcode && slot_en[0] && fetch_addr == slot_addr[0]) |-> (redirect && redirect_addr == slot_vector(0)));

    genvar g;
    generate
        for (g = 0; g < NUM_SLOTS; g++) begin : g_chk
            // A slot's vector appears only for an enabled, matching slot (R6).
            assert_vector_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (redirect && redirect_addr == slot_vector(g)) |-> (slot_en[g] && fetch_addr == slot_addr[g]));
        end
    endgenerate
endmodule

// File: tb/rom_patch_redirect_bench.sv
// Bench: directed corner cases followed by seeded random traffic, checked
// against a bench-side model of the registers and the redirect rule.
module rom_patch_redirect_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] reg_addr = 16'h0;
    logic [7:0]  reg_wdata = 8'h0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_rdata;
    logic [15:0] fetch_addr = 16'h0;
    logic        fetch_opcode = 1'b0;
    logic        redirect;
    logic [15:0] redirect_addr;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [15:0] m_slot [2];
    logic [1:0]  m_en;

    rom_patch_redirect u_rom_patch_redirect (
        .clk (clk), .rst_n (rst_n),
        .reg_addr (reg_addr), .reg_wdata (reg_wdata), .reg_we (reg_we),
        .reg_rdata (reg_rdata),
        .fetch_addr (fetch_addr), .fetch_opcode (fetch_opcode),
        .redirect (redirect), .redirect_addr (redirect_addr)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Model of the register read map.
    function automatic logic [7:0] exp_read(input logic [15:0] a);
        case (a)
            16'h020A: return m_slot[0][15:8];
            16'h020B: return m_slot[0][7:0];
            16'h020C: return m_slot[1][15:8];
            16'h020D: return m_slot[1][7:0];
            16'h020E: return {6'b0, m_en};
            default:  return 8'h00;
        endcase
    endfunction

    // Model of the redirect vector (0 means no redirect).
    function automatic logic [15:0] exp_vec(input logic [15:0] a, input logic op);
        if (op && m_en[0] && a == m_slot[0]) return 16'h0300;
        if (op && m_en[1] && a == m_slot[1]) return 16'h0320;
        return 16'h0000;
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
        case (a)
            16'h020A: m_slot[0][15:8] = d;
            16'h020B: m_slot[0][7:0]  = d;
            16'h020C: m_slot[1][15:8] = d;
            16'h020D: m_slot[1][7:0]  = d;
            16'h020E: m_en = d[1:0];
            default: ;
        endcase
    endtask

    task automatic check_read(input logic [15:0] a, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(tag, {8'h0, reg_rdata}, {8'h0, exp_read(a)});
    endtask

    task automatic check_fetch(input logic [15:0] a, input logic op, input string tag);
        logic [15:0] e;
        @(negedge clk);
        fetch_addr = a; fetch_opcode = op;
        #1;
        e = exp_vec(a, op);
        check(tag, {15'h0, redirect}, {15'h0, (e != 16'h0)});
        check(tag, redirect_addr, e);
        @(negedge clk);
        fetch_opcode = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] a;
        logic [15:0] ra;
        m_slot[0] = 16'h0; m_slot[1] = 16'h0; m_en = 2'b0;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int r = 16'h020A; r <= 16'h020E; r++) check_read(16'(r), "R1 reset read");
        check_fetch(16'h0000, 1'b1, "R1 no redirect after reset");

        // R2, R3: address readback
        do_write(16'h020A, 8'h81); do_write(16'h020B, 8'h23);
        check_read(16'h020A, "R2 slot1 high"); check_read(16'h020B, "R2 slot1 low");
        do_write(16'h020C, 8'h94); do_write(16'h020D, 8'h56);
        check_read(16'h020C, "R3 slot2 high"); check_read(16'h020D, "R3 slot2 low");

        // R4: enable with padding bits
        do_write(16'h020E, 8'hFF);
        check_read(16'h020E, "R4 enable pad reads zero");

        // R5: hits on each slot
        check_fetch(16'h8123, 1'b1, "R5 slot1 vector");
        check_fetch(16'h9456, 1'b1, "R5 slot2 vector");
        // R7: operand fetch at a patched address
        check_fetch(16'h8123, 1'b0, "R7 operand fetch");
        // R9: miss gives zero vector
        check_fetch(16'h8124, 1'b1, "R9 miss vector zero");
        // R6: disabled slot
        do_write(16'h020E, 8'h02);
        check_fetch(16'h8123, 1'b1, "R6 slot1 disabled");
        check_fetch(16'h9456, 1'b1, "R6 slot2 still enabled");

        // R10: unmapped addresses
        do_write(16'h020F, 8'hFF); do_write(16'h0209, 8'h77);
        check_read(16'h020F, "R10 unmapped read");
        check_read(16'h0209, "R10 unmapped read");
        check_read(16'h020E, "R10 enable untouched");
        check_read(16'h020B, "R10 slot untouched");

        // R8: both slots on the same address
        do_write(16'h020A, 8'h40); do_write(16'h020B, 8'h00);
        do_write(16'h020C, 8'h40); do_write(16'h020D, 8'h00);
        do_write(16'h020E, 8'h03);
        check_fetch(16'h4000, 1'b1, "R8 slot1 priority");

        // Random mix over R2 R3 R4 R5 R6 R7 R8 R9 R10
        for (int k = 0; k < 600; k++) begin
            case ($urandom % 4)
                0: begin
                    ra = 16'h0208 + 16'($urandom % 9);
                    do_write(ra, 8'($urandom));
                end
                1: begin
                    ra = 16'h0208 + 16'($urandom % 9);
                    check_read(ra, "R2 R3 R4 R10 random read");
                end
                default: begin
                    case ($urandom % 3)
                        0: a = m_slot[0];
                        1: a = m_slot[1];
                        default: a = 16'($urandom);
                    endcase
                    check_fetch(a, 1'($urandom), "R5 R6 R7 R8 R9 random fetch");
                end
            endcase
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule